// File: doc/BRIEF.md
# Vertical-Blank Oscillator Trim Calibrator

This block closes a slow digital loop around a tunable filter that can be switched into a free-running oscillator. Each time vertical sync rises, it opens a fixed calibration window measured in reference-clock periods. The window is split into back-to-back measurement gates. In each gate the block counts rising edges of the oscillator, which arrive asynchronously and pass through a two-flop synchronizer. At the end of each gate it compares the count with the expected count for the selected band. If the count is low, it raises a 6-bit trim code by one. If the count is high, it lowers the code by one. Each change is marked by a one-cycle enable strobe, which an external converter uses to load the new control voltage.

Once a gate lands inside the band's tolerance, the loop declares lock and freezes the code. The code stays frozen through later fields until reset or a band change. The block runs on a fast system clock. The reference timing reaches it as a one-cycle tick per reference period, so a gate of 443 ticks spans 100 µs when the reference is 4.43 MHz.

Top module: `vblank_osc_cal`

## Requirements
- R1: After reset the trim code is 32 (mid-scale), the strobe is low and the lock flag is low.
- R2: A rising edge of `vsync` restarts a window of 3101 reference ticks. Gate evaluations happen only inside the window, and `trim_en` never pulses outside it.
- R3: Each window holds consecutive gates of 443 reference ticks. Within a gate, the block counts rising edges of `osc_in` as seen after a two-flop synchronizer. The edge seen in the last cycle of a gate belongs to that gate.
- R4: At a gate end with lock low, the code goes up by one when the count is below the lower tolerance limit and down by one when it is above the upper limit. In the cycle after the gate end, `trim_en` is high for exactly one cycle and carries the new code.
- R5: The code saturates at 0 and 63 with no wraparound. A gate that asks to pass a limit still pulses `trim_en`, but the code does not change.
- R6: The target and tolerance depend on the band. `band_sel`=1 selects the high band (429 counts ±4). `band_sel`=0 selects the low band (107 counts ±1). A count within the limits (inclusive) sets the lock flag, leaves the code unchanged and gives no strobe.
- R7: While locked, the code does not change and `trim_en` stays low in every later gate and field.
- R8: A change of `band_sel` clears the lock flag in the next cycle and discards the gate in progress. The next full gate is then evaluated against the new band.
- R9: `trim_code` changes only in cycles where `trim_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle tick per reference-clock period |
| osc_in | input | 1 | Oscillator output, asynchronous |
| vsync | input | 1 | Vertical sync; rising edge starts a window |
| band_sel | input | 1 | 1 = high band, 0 = low band |
| trim_code | output | 6 | Trim code for the control-voltage converter |
| trim_en | output | 1 | One-cycle load strobe for a new code |
| locked | output | 1 | Error within band tolerance; updates frozen |

## Verification
The bench pushes the code into both rails. This checks that a design which wraps, or which stops strobing at the rail, is caught: a wrapping design would jump from 63 to 0, and one that drops the strobe would give too few pulses per field. It also runs an oscillator rate that lands inside the tolerance, then switches to a rate far outside it in the next field. A design that keeps adjusting after lock would move the code at that point. A band switch right after lock must drop the flag within one cycle and retarget the count. A design that keeps the old gate or the old lock would give the wrong code after the next field. Strobes that fall after the window closes are counted separately, as are code changes made without a strobe.

// File: rtl/vcal_pkg.sv
package vcal_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/vcal_edge_sync.sv
module vcal_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/vcal_timebase.sv
module vcal_timebase #(
    parameter int WIN_TICKS  = 3101,
    parameter int GATE_TICKS = 443
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic vsync,
    input  logic band_sel,
    output logic win_active,
    output logic cnt_clr,
    output logic gate_end,
    output logic band_chg
);
    localparam int WIN_W  = $clog2(WIN_TICKS);
    localparam int GATE_W = $clog2(GATE_TICKS);

    typedef struct packed {
        logic              vs_prev;
        logic              band_prev;
        logic              active;
        logic [WIN_W-1:0]  win;
        logic [GATE_W-1:0] gate;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      vs_rise;

    always_comb begin
        st_d         = st_q;
        st_d.vs_prev = vsync;
        st_d.band_prev = band_sel;
        vs_rise      = vsync & ~st_q.vs_prev;
        band_chg     = band_sel ^ st_q.band_prev;
        cnt_clr      = vs_rise | band_chg;
        gate_end     = 1'b0;
        if (vs_rise) begin
            st_d.active = 1'b1;
            st_d.win    = '0;
            st_d.gate   = '0;
        end else if (band_chg) begin
            st_d.gate   = '0;
        end else if (st_q.active && ref_tick) begin
            if (st_q.gate == GATE_W'(GATE_TICKS - 1)) begin
                gate_end  = 1'b1;
                st_d.gate = '0;
            end else begin
                st_d.gate = st_q.gate + 1'b1;
            end
            if (st_q.win == WIN_W'(WIN_TICKS - 1)) st_d.active = 1'b0;
            else                                    st_d.win    = st_q.win + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_active = st_q.active;
endmodule

// File: rtl/vcal_trim.sv
module vcal_trim
    import vcal_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int TGT_HI = 429,
    parameter int TGT_LO = 107,
    parameter int TOL_HI = 4,
    parameter int TOL_LO = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_rise,
    input  logic              win_active,
    input  logic              cnt_clr,
    input  logic              gate_end,
    input  logic              band_chg,
    input  logic              band_sel,
    output logic [CODE_W-1:0] trim_code,
    output logic              trim_en,
    output logic              locked
);
    localparam int TGT_MAX  = (TGT_HI > TGT_LO) ? TGT_HI : TGT_LO;
    localparam int CNT_W    = $clog2(2 * TGT_MAX + 2);
    localparam int CNT_MAX  = (1 << CNT_W) - 1;
    localparam int CODE_MAX = (1 << CODE_W) - 1;
    localparam int CODE_MID = 1 << (CODE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] code;
        logic              en;
        logic              lock;
    } trim_state_t;

    trim_state_t      st_d, st_q;
    logic [CNT_W-1:0] meas;
    int               lo_lim, hi_lim;
    step_e            step;

    always_comb begin
        meas = st_q.cnt;
        if (osc_rise && st_q.cnt != CNT_W'(CNT_MAX)) meas = st_q.cnt + 1'b1;

        lo_lim = band_sel ? (TGT_HI - TOL_HI) : (TGT_LO - TOL_LO);
        hi_lim = band_sel ? (TGT_HI + TOL_HI) : (TGT_LO + TOL_LO);
        if (int'(meas) < lo_lim)      step = STEP_UP;
        else if (int'(meas) > hi_lim) step = STEP_DOWN;
        else                          step = STEP_NONE;

        st_d    = st_q;
        st_d.en = 1'b0;
        if (cnt_clr || gate_end) st_d.cnt = '0;
        else if (win_active)     st_d.cnt = meas;

        if (gate_end && !st_q.lock) begin
            unique case (step)
                STEP_UP: begin
                    st_d.en = 1'b1;
                    if (st_q.code != CODE_W'(CODE_MAX)) st_d.code = st_q.code + 1'b1;
                end
                STEP_DOWN: begin
                    st_d.en = 1'b1;
                    if (st_q.code != '0) st_d.code = st_q.code - 1'b1;
                end
                default: st_d.lock = 1'b1;
            endcase
        end
        if (band_chg) st_d.lock = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.code <= CODE_W'(CODE_MID);
        end else begin
            st_q <= st_d;
        end
    end

    assign trim_code = st_q.code;
    assign trim_en   = st_q.en;
    assign locked    = st_q.lock;
endmodule

// File: rtl/vblank_osc_cal.sv
module vblank_osc_cal #(
    parameter int CODE_W      = 6,
    parameter int SYNC_STAGES = 2,
    parameter int WIN_TICKS   = 3101,
    parameter int GATE_TICKS  = 443,
    parameter int TGT_HI      = 429,
    parameter int TGT_LO      = 107,
    parameter int TOL_HI      = 4,
    parameter int TOL_LO      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              osc_in,
    input  logic              vsync,
    input  logic              band_sel,
    output logic [CODE_W-1:0] trim_code,
    output logic              trim_en,
    output logic              locked
);
    logic osc_rise, win_active, cnt_clr, gate_end, band_chg;

    vcal_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (osc_in),
        .rise     (osc_rise)
    );

    vcal_timebase #(.WIN_TICKS(WIN_TICKS), .GATE_TICKS(GATE_TICKS)) u_time (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .vsync      (vsync),
        .band_sel   (band_sel),
        .win_active (win_active),
        .cnt_clr    (cnt_clr),
        .gate_end   (gate_end),
        .band_chg   (band_chg)
    );

    vcal_trim #(
        .CODE_W (CODE_W),
        .TGT_HI (TGT_HI),
        .TGT_LO (TGT_LO),
        .TOL_HI (TOL_HI),
        .TOL_LO (TOL_LO)
    ) u_trim (
        .clk        (clk),
        .rst_n      (rst_n),
        .osc_rise   (osc_rise),
        .win_active (win_active),
        .cnt_clr    (cnt_clr),
        .gate_end   (gate_end),
        .band_chg   (band_chg),
        .band_sel   (band_sel),
        .trim_code  (trim_code),
        .trim_en    (trim_en),
        .locked     (locked)
    );
endmodule

// File: rtl/vblank_osc_cal_chk.sv
module vblank_osc_cal_chk #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              band_sel,
    input logic              win_active,
    input logic [CODE_W-1:0] trim_code,
    input logic              trim_en,
    input logic              locked
);
    // R9: the code only moves together with its strobe
    p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trim_en |-> $stable(trim_code));

    // R4 / R5: a strobe moves the code by at most one step
    p_step_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trim_en |-> (trim_code == $past(trim_code) + 1'b1) ||
                    (trim_code == $past(trim_code) - 1'b1) ||
                    (trim_code == $past(trim_code)));

    // R4: the strobe is a single cycle
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trim_en |=> !trim_en);

    // R2: strobes originate only from inside the window
    p_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trim_en |-> $past(win_active));

    // R7: no strobe while lock persists
    p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> !trim_en);

    // R8: a band change drops lock in the following cycle
    p_band_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (band_sel != $past(band_sel)) |=> !locked);
endmodule

bind vblank_osc_cal vblank_osc_cal_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .band_sel   (band_sel),
    .win_active (win_active),
    .trim_code  (trim_code),
    .trim_en    (trim_en),
    .locked     (locked)
);

// File: tb/tb_vblank_osc_cal.sv
module tb_vblank_osc_cal;
    localparam int WIN   = 3101;
    localparam int GATE  = 443;
    localparam int FIELD = 6400;
    localparam int GATE_CYC = 2 * GATE;   // ref_tick every second clock
    localparam int WIN_END  = 2 * WIN + 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       osc_in = 1'b0;
    logic       vsync = 1'b0;
    logic       band_sel = 1'b1;
    logic [5:0] trim_code;
    logic       trim_en;
    logic       locked;

    always #4 clk = ~clk;

    vblank_osc_cal dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .osc_in    (osc_in),
        .vsync     (vsync),
        .band_sel  (band_sel),
        .trim_code (trim_code),
        .trim_en   (trim_en),
        .locked    (locked)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int cyc = 0, acc = 0, rate = 0, fpos = 0;
    int fld_en = 0, fld_out = 0, bad_move = 0;
    int prev_code = 32;

    // behavioural reference
    bit osc_hist[$];
    int m_code, m_cnt, m_gate, m_win;
    bit m_en, m_lock, m_act, m_vs_prev, m_band_prev;

    task automatic model_reset();
        m_code = 32; m_cnt = 0; m_gate = 0; m_win = 0;
        m_en = 0; m_lock = 0; m_act = 0; m_vs_prev = 0; m_band_prev = 0;
        osc_hist = '{0, 0, 0};
    endtask

    task automatic model_step();
        bit e, vr, bc, gend;
        int meas, tgt, tol;
        e    = osc_hist[1] && !osc_hist[2];
        vr   = vsync && !m_vs_prev;
        bc   = (band_sel != m_band_prev);
        gend = 0;
        m_en = 0;
        if (vr) begin
            m_act = 1; m_win = 0; m_gate = 0; m_cnt = 0;
        end else if (bc) begin
            m_gate = 0; m_cnt = 0;
        end else if (m_act) begin
            meas = m_cnt + e;
            if (ref_tick) begin
                if (m_gate == GATE - 1) begin gend = 1; m_gate = 0; end
                else m_gate++;
                if (m_win == WIN - 1) m_act = 0; else m_win++;
            end
            m_cnt = gend ? 0 : meas;
            if (gend && !m_lock) begin
                tgt = band_sel ? 429 : 107;
                tol = band_sel ? 4 : 1;
                if (meas < tgt - tol) begin
                    m_en = 1; if (m_code < 63) m_code++;
                end else if (meas > tgt + tol) begin
                    m_en = 1; if (m_code > 0) m_code--;
                end else begin
                    m_lock = 1;
                end
            end
        end
        if (bc) m_lock = 0;
        m_vs_prev = vsync;
        m_band_prev = band_sel;
        osc_hist.push_front(osc_in);
        void'(osc_hist.pop_back());
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check(int'(trim_code) == m_code, "R3/R4 code vs model", int'(trim_code), m_code);
        check(trim_en == m_en, "R4 strobe vs model", int'(trim_en), int'(m_en));
        check(locked == m_lock, "R6 lock vs model", int'(locked), int'(m_lock));
        if (trim_en) begin
            fld_en++;
            if (fpos > WIN_END) fld_out++;
        end
        if (!trim_en && int'(trim_code) != prev_code) bad_move++;
        prev_code = int'(trim_code);
    endtask

    task automatic cycle(input bit vs);
        @(negedge clk);
        compare_outputs();
        cyc++;
        fpos++;
        ref_tick = cyc[0];
        acc += rate;
        if (acc >= GATE_CYC) begin acc -= GATE_CYC; osc_in = 1'b1; end
        else osc_in = 1'b0;
        vsync = vs;
        model_step();
    endtask

    task automatic run_field(input int r);
        rate = r; fpos = 0; fld_en = 0; fld_out = 0;
        for (int i = 0; i < FIELD; i++) cycle(i < 4);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vsync = 1'b0; osc_in = 1'b0; rate = 0; acc = 0;
        repeat (4) @(negedge clk);
        model_reset();
        prev_code = 32;
        check(trim_code == 6'd32, "R1 reset code", int'(trim_code), 32);
        check(trim_en == 1'b0, "R1 reset strobe", int'(trim_en), 0);
        check(locked == 1'b0, "R1 reset lock", int'(locked), 0);
        rst_n = 1'b1;
        model_step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // scenario A: high band, oscillator slow -> code climbs to the top rail
        band_sel = 1'b1;
        do_reset();
        run_field(300);
        check(trim_code == 6'd39, "R4 seven up-steps per field", int'(trim_code), 39);
        check(fld_en == 7, "R3 one strobe per gate", fld_en, 7);
        for (int f = 0; f < 4; f++) run_field(300);
        check(trim_code == 6'd63, "R5 saturate at 63", int'(trim_code), 63);
        check(fld_en == 7, "R5 strobe kept at rail", fld_en, 7);
        check(fld_out == 0, "R2 no strobe after window", fld_out, 0);

        // scenario B: oscillator fast -> code falls to the bottom rail
        do_reset();
        run_field(440);
        check(trim_code == 6'd25, "R4 seven down-steps per field", int'(trim_code), 25);
        for (int f = 0; f < 4; f++) run_field(440);
        check(trim_code == 6'd0, "R5 saturate at 0", int'(trim_code), 0);

        // scenario C: lock, freeze, band change, low-band lock
        do_reset();
        run_field(429);
        check(locked == 1'b1, "R6 high band lock", int'(locked), 1);
        check(trim_code == 6'd32, "R6 code held on lock", int'(trim_code), 32);
        check(fld_en == 0, "R6 no strobe on lock", fld_en, 0);
        run_field(300);
        check(trim_code == 6'd32, "R7 frozen while locked", int'(trim_code), 32);
        check(fld_en == 0, "R7 no strobe while locked", fld_en, 0);
        @(negedge clk); band_sel = 1'b0; model_step();
        cycle(1'b0);
        check(locked == 1'b0, "R8 band change clears lock", int'(locked), 0);
        run_field(300);
        check(trim_code == 6'd25, "R8 retarget to low band", int'(trim_code), 25);
        run_field(107);
        check(locked == 1'b1, "R6 low band lock", int'(locked), 1);
        check(trim_code == 6'd25, "R6 low band code held", int'(trim_code), 25);
        check(bad_move == 0, "R9 code moved without strobe", bad_move, 0);
        finish_run();
    end
endmodule